// File: doc/BRIEF.md
# DRAM Channel Issue Arbiter with Credit Pools

This block chooses which of several cache sub-partitions sharing one DRAM channel may hand a request to that channel in a given cycle. Each requester shows a request flag, a direction flag (read or write) and a flag saying its own reply queue is full. The channel reports one full flag per direction. At most one requester is granted per cycle. Only the grant index, the credit bookkeeping and the round-robin pointer are held here. Request payloads, the DRAM and the cache stay outside.

Before a requester may issue, it must hold credit. Each requester has one private credit of its own. Once that is spent, it draws from a pool shared by all requesters. The size of that pool comes from the scheduler, reply and optional write queue depths. The search is round-robin and starts just after the requester that last borrowed credit. Credits come back through a return pulse tagged with the requester index.

Top module: `dram_credit_arbiter`

## Requirements
- R1: Out of synchronous active-high reset, `gnt_vld`=0, `last_ptr`=N-1, `priv_held`=0, `shared_cnt`=0 and `credit_err`=0.
- R2: The first credit a requester takes is its private one: `priv_held[i]` goes to 1, and `shared_cnt` is left unchanged.
- R3: The shared limit is SCHED_DEPTH + RET_DEPTH - (N-1), plus WRQ_DEPTH when SEP_WRQ=1. A requester holding its private credit is not granted while `shared_cnt` equals that limit.
- R4: When SCHED_DEPTH or RET_DEPTH is 0, the shared pool has no limit, and a requester holding its private credit keeps being granted.
- R5: Requester i is eligible only when `req_vld[i]`=1, it holds credit, and `ret_full[i]`=0.
- R6: The search visits indices (last_ptr+1+p) mod N for p=0..N-1. The first eligible one is the candidate. On a grant, `last_ptr` takes the granted index.
- R7: If the candidate has `req_wr`=1 (write) and `dram_wr_full`=1, or `req_wr`=0 (read) and `dram_rd_full`=1, no grant is made that cycle. No later requester is tried, and `last_ptr` is unchanged.
- R8: At most one grant is made per cycle. Inputs sampled at a clock edge show up on `gnt_vld`/`gnt_idx`, `last_ptr` and the counts after that same edge.
- R9: A return for requester i clears `priv_held[i]` if it is set, and otherwise decrements `shared_cnt`. A return is applied before the same cycle's arbitration, so it can fund that cycle's borrow.
- R10: A return for a requester with `priv_held[i]`=0 while `shared_cnt`=0 changes no count and pulses `credit_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N | Request pending, one bit per requester |
| req_wr | input | N | Request direction, 1 = write |
| ret_full | input | N | Requester reply queue full |
| dram_rd_full | input | 1 | Channel cannot take a read |
| dram_wr_full | input | 1 | Channel cannot take a write |
| ret_vld | input | 1 | Credit return pulse |
| ret_idx | input | IW | Requester the returned credit belongs to |
| gnt_vld | output | 1 | Grant issued (registered) |
| gnt_idx | output | IW | Granted requester (registered) |
| last_ptr | output | IW | Requester that last borrowed credit |
| priv_held | output | N | Private credit in use, one bit per requester |
| shared_cnt | output | CW | Shared credits in use |
| credit_err | output | 1 | Return arrived with no credit outstanding |

## Verification
The hardest case to reach is a drained shared pool that meets a full DRAM direction and a return in the same cycle. That needs credits held back over many cycles while requests keep arriving. The bench runs a small configuration whose shared pool holds a single credit, so the pool drains after a handful of grants. A long random sweep then draws returns sparsely, so the pool stays near its limit most of the time. A reference model computed in the bench is compared every cycle. Instances with an unlimited pool and with the write queue added are driven with the same inputs to check the limit formula.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;
  // Shared credit pool size; 0 means no limit.
  function automatic int shared_limit(int sched, int ret, int wrq, bit sep, int n);
    int lim;
    if (sched == 0 || ret == 0) return 0;
    lim = sched + ret - (n - 1);
    if (sep) lim = lim + wrq;
    return lim;
  endfunction
endpackage

// File: rtl/dca_credit_pool.sv
`timescale 1ns/1ps
module dca_credit_pool #(
  parameter int N     = 4,
  parameter int IW    = 2,
  parameter int CW    = 4,
  parameter int LIMIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ret_vld,
  input  logic [IW-1:0] ret_idx,
  input  logic          bor_vld,
  input  logic [IW-1:0] bor_idx,
  output logic [N-1:0]  has_credit,
  output logic [N-1:0]  held_q,
  output logic [CW-1:0] shared_q,
  output logic          err_q
);
  logic [N-1:0]  held_r, held_n;
  logic [CW-1:0] sh_r, sh_n;
  logic          err_c;

  // Return is settled first; arbitration sees the post-return state.
  always_comb begin
    held_r = held_q;
    sh_r   = shared_q;
    err_c  = 1'b0;
    if (ret_vld) begin
      if (held_q[ret_idx])       held_r[ret_idx] = 1'b0;
      else if (shared_q != '0)   sh_r = shared_q - 1'b1;
      else                       err_c = 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_cred
      if (LIMIT == 0) begin : g_unl
        assign has_credit[i] = 1'b1;
      end else begin : g_lim
        assign has_credit[i] = !held_r[i] || (int'(sh_r) < LIMIT);
      end
    end
  endgenerate

  always_comb begin
    held_n = held_r;
    sh_n   = sh_r;
    if (bor_vld) begin
      if (!held_r[bor_idx]) held_n[bor_idx] = 1'b1;
      else                  sh_n = sh_r + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      shared_q <= '0;
      err_q    <= 1'b0;
    end else begin
      held_q   <= held_n;
      shared_q <= sh_n;
      err_q    <= err_c;
    end
  end

  // R3
  shared_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (LIMIT != 0) |-> (int'(shared_q) <= LIMIT));

  // R5
  borrow_funded_chk: assert property (@(posedge clk) disable iff (rst)
    bor_vld |-> has_credit[bor_idx]);

  // R10
  err_keeps_counts_chk: assert property (@(posedge clk) disable iff (rst)
    err_c |=> ($past(shared_q) == shared_q || $past(bor_vld)));
endmodule

// File: rtl/dca_rr_pick.sv
`timescale 1ns/1ps
module dca_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] last,
  input  logic [N-1:0]  req_vld,
  input  logic [N-1:0]  req_wr,
  input  logic [N-1:0]  ret_full,
  input  logic [N-1:0]  credit,
  input  logic          rd_full,
  input  logic          wr_full,
  output logic          pick_vld,
  output logic [IW-1:0] pick_idx
);
  logic found;

  always_comb begin
    found    = 1'b0;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int p = 0; p < N; p++) begin
      int idx;
      idx = (int'(last) + 1 + p) % N;
      if (!found && req_vld[idx] && credit[idx] && !ret_full[idx]) begin
        found = 1'b1;
        // Candidate blocked by a full direction ends the search.
        if (!(req_wr[idx] ? wr_full : rd_full)) begin
          pick_vld = 1'b1;
          pick_idx = IW'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/dram_credit_arbiter.sv
`timescale 1ns/1ps
module dram_credit_arbiter #(
  parameter int N           = 4,
  parameter int SCHED_DEPTH = 2,
  parameter int RET_DEPTH   = 2,
  parameter int WRQ_DEPTH   = 2,
  parameter bit SEP_WRQ     = 1'b0,
  parameter int IW          = (N > 1) ? $clog2(N) : 1,
  parameter int LIMIT       = dca_pkg::shared_limit(SCHED_DEPTH, RET_DEPTH, WRQ_DEPTH, SEP_WRQ, N),
  parameter int CW          = (LIMIT == 0) ? 8 : $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_vld,
  input  logic [N-1:0]  req_wr,
  input  logic [N-1:0]  ret_full,
  input  logic          dram_rd_full,
  input  logic          dram_wr_full,
  input  logic          ret_vld,
  input  logic [IW-1:0] ret_idx,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx,
  output logic [IW-1:0] last_ptr,
  output logic [N-1:0]  priv_held,
  output logic [CW-1:0] shared_cnt,
  output logic          credit_err
);
  logic [N-1:0]  credit;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] last_q;
  logic          gnt_vld_q;
  logic [IW-1:0] gnt_idx_q;

  dca_credit_pool #(.N(N), .IW(IW), .CW(CW), .LIMIT(LIMIT)) u_pool (
    .clk(clk), .rst(rst),
    .ret_vld(ret_vld), .ret_idx(ret_idx),
    .bor_vld(pick_vld), .bor_idx(pick_idx),
    .has_credit(credit), .held_q(priv_held),
    .shared_q(shared_cnt), .err_q(credit_err)
  );

  dca_rr_pick #(.N(N), .IW(IW)) u_pick (
    .last(last_q), .req_vld(req_vld), .req_wr(req_wr), .ret_full(ret_full),
    .credit(credit), .rd_full(dram_rd_full), .wr_full(dram_wr_full),
    .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= IW'(N - 1);
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
    end else begin
      gnt_vld_q <= pick_vld;
      if (pick_vld) begin
        last_q    <= pick_idx;
        gnt_idx_q <= pick_idx;
      end
    end
  end

  assign gnt_vld  = gnt_vld_q;
  assign gnt_idx  = gnt_idx_q;
  assign last_ptr = last_q;

  // R5
  gnt_had_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> ((($past(req_vld) & ~$past(ret_full)) >> gnt_idx) & N'(1)) != '0);

  // R6
  last_tracks_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> (last_ptr == gnt_idx));

  // R7
  last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gnt_vld |-> $stable(last_ptr));

  // R8
  one_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> ($countones(priv_held ^ $past(priv_held)) <= 2));
endmodule

// File: tb/sim_dram_credit_arbiter.sv
`timescale 1ns/1ps
module sim_dram_credit_arbiter;
  localparam int N = 4;
  localparam int IW = 2;
  localparam int LIM0 = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_vld = '0, req_wr = '0, ret_full = '0;
  logic dram_rd_full = 1'b0, dram_wr_full = 1'b0, ret_vld = 1'b0;
  logic [IW-1:0] ret_idx = '0;

  logic gv0, gv1, gv2, er0, er1, er2;
  logic [IW-1:0] gi0, gi1, gi2, lp0, lp1, lp2;
  logic [N-1:0] ph0, ph1, ph2;
  logic [0:0] sc0;
  logic [7:0] sc1;
  logic [1:0] sc2;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_held[N];
  int m_sh, m_last, m_gv, m_gi, m_err;

  always #10 clk = ~clk;

  dram_credit_arbiter #(.N(N), .SCHED_DEPTH(2), .RET_DEPTH(2), .SEP_WRQ(1'b0)) u0 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .ret_full(ret_full),
    .dram_rd_full(dram_rd_full), .dram_wr_full(dram_wr_full), .ret_vld(ret_vld),
    .ret_idx(ret_idx), .gnt_vld(gv0), .gnt_idx(gi0), .last_ptr(lp0),
    .priv_held(ph0), .shared_cnt(sc0), .credit_err(er0));

  dram_credit_arbiter #(.N(N), .SCHED_DEPTH(0), .RET_DEPTH(2)) u1 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .ret_full(ret_full),
    .dram_rd_full(dram_rd_full), .dram_wr_full(dram_wr_full), .ret_vld(ret_vld),
    .ret_idx(ret_idx), .gnt_vld(gv1), .gnt_idx(gi1), .last_ptr(lp1),
    .priv_held(ph1), .shared_cnt(sc1), .credit_err(er1));

  dram_credit_arbiter #(.N(N), .SCHED_DEPTH(2), .RET_DEPTH(2), .WRQ_DEPTH(2), .SEP_WRQ(1'b1)) u2 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .ret_full(ret_full),
    .dram_rd_full(dram_rd_full), .dram_wr_full(dram_wr_full), .ret_vld(ret_vld),
    .ret_idx(ret_idx), .gnt_vld(gv2), .gnt_idx(gi2), .last_ptr(lp2),
    .priv_held(ph2), .shared_cnt(sc2), .credit_err(er2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_held[i] = 0;
    m_sh = 0; m_last = N - 1; m_gv = 0; m_gi = 0; m_err = 0;
  endtask

  task automatic model_step();
    int found, idx, blk;
    m_err = 0;
    if (ret_vld) begin
      if (m_held[ret_idx] != 0) m_held[ret_idx] = 0;
      else if (m_sh > 0) m_sh--;
      else m_err = 1;
    end
    found = 0; m_gv = 0;
    for (int p = 0; p < N; p++) begin
      idx = (m_last + 1 + p) % N;
      if (!found && req_vld[idx] && (m_held[idx] == 0 || m_sh < LIM0) && !ret_full[idx]) begin
        found = 1;
        blk = req_wr[idx] ? dram_wr_full : dram_rd_full;
        if (!blk) begin m_gv = 1; m_gi = idx; end
      end
    end
    if (m_gv) begin
      if (m_held[m_gi] == 0) m_held[m_gi] = 1; else m_sh++;
      m_last = m_gi;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_vld = '0; req_wr = '0; ret_full = '0;
    dram_rd_full = 0; dram_wr_full = 0; ret_vld = 0; ret_idx = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic cyc(input logic [N-1:0] rv, input logic [N-1:0] rw, input logic [N-1:0] rf,
                     input logic drf, input logic dwf, input logic crv, input int cri);
    int hv;
    @(negedge clk);
    req_vld = rv; req_wr = rw; ret_full = rf; dram_rd_full = drf; dram_wr_full = dwf;
    ret_vld = crv; ret_idx = IW'(cri);
    model_step();
    @(posedge clk);
    #1;
    hv = 0;
    for (int i = 0; i < N; i++) hv = hv | (m_held[i] << i);
    chk(gv0 == m_gv[0] && (!m_gv || gi0 == IW'(m_gi)) && lp0 == IW'(m_last) &&
        int'(ph0) == hv && int'(sc0) == m_sh && er0 == m_err[0],
        "R5 R6 R7 R8 R9 model gnt/idx", {gv0, gi0}, {m_gv[0], IW'(m_gi)});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1
    chk(gv0 == 0 && er0 == 0, "R1 gnt/err", gv0, 0);
    chk(lp0 == 2'd3, "R1 last_ptr", lp0, 3);
    chk(ph0 == 0 && sc0 == 0, "R1 counts", ph0, 0);

    // R2 private first; R3/R4 limits across instances
    cyc(4'b0001, 0, 0, 0, 0, 0, 0);
    chk(gv0 && gi0 == 0 && ph0 == 4'b0001 && sc0 == 0, "R2 private taken", sc0, 0);
    for (int k = 0; k < 5; k++) cyc(4'b0001, 0, 0, 0, 0, 0, 0);
    chk(sc0 == 1 && !gv0, "R3 limit 1 holds", sc0, 1);
    chk(sc2 == 2'd3 && !gv2, "R3 write queue adds to limit", sc2, 3);
    chk(sc1 == 8'd5 && gv1, "R4 unlimited pool", sc1, 5);

    // R6 rotation
    do_reset();
    for (int k = 0; k < N; k++) begin
      cyc(4'b1111, 0, 0, 0, 0, 0, 0);
      chk(gv0 && gi0 == IW'(k), "R6 round robin order", gi0, k);
    end

    // R5 reply queue full skips requester
    do_reset();
    cyc(4'b0011, 0, 4'b0001, 0, 0, 0, 0);
    chk(gv0 && gi0 == 1, "R5 ret_full skipped", gi0, 1);

    // R7 full direction stops the search
    do_reset();
    cyc(4'b0011, 4'b0001, 0, 0, 1, 0, 0);
    chk(!gv0 && lp0 == 3, "R7 blocked write stalls", gv0, 0);
    cyc(4'b0011, 4'b0001, 0, 1, 0, 0, 0);
    chk(gv0 && gi0 == 0, "R7 write proceeds", gi0, 0);

    // R9 return ordering
    do_reset();
    cyc(4'b0001, 0, 0, 0, 0, 0, 0);
    cyc(4'b0001, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(ph0 == 0 && sc0 == 1, "R9 private returned first", ph0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(sc0 == 0, "R9 shared returned", sc0, 0);
    cyc(4'b0001, 0, 0, 0, 0, 0, 0);
    cyc(4'b0001, 0, 0, 0, 0, 1, 0);
    chk(gv0 && ph0 == 4'b0001 && sc0 == 0, "R9 same-cycle return funds borrow", sc0, 0);

    // R10 spurious return
    do_reset();
    cyc(0, 0, 0, 0, 0, 1, 2);
    chk(er0 && sc0 == 0 && ph0 == 0, "R10 err pulse", er0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(!er0, "R10 err one cycle", er0, 0);

    // Sweep against the model
    do_reset();
    void'($urandom(7));
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rv, rw, rf;
      logic drf, dwf, crv;
      rv = N'($urandom);
      rw = N'($urandom);
      rf = (($urandom % 6) == 0) ? N'($urandom) : '0;
      drf = (($urandom % 7) == 0);
      dwf = (($urandom % 5) == 0);
      crv = (($urandom % 3) == 0);
      cyc(rv, rw, rf, drf, dwf, crv, int'($urandom % N));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule